// File: doc/BRIEF.md
# Bit Field Extract Unit

This unit takes a data word and pulls out a contiguous run of bits from it. The run is returned right-justified, and every bit above it is zero. One control word carries both the position of the lowest bit to take (the start) and the number of bits to take (the length). A mode input selects a 32-bit or a 64-bit operand size. A start or length that does not fit the operand size is clamped to the operand and never wraps. Besides the result, the unit drives a six-bit condition-flag vector in which only the zero flag can ever be set.

The unit has one register stage. An operand is accepted in every cycle in which `in_valid` is high. Its result and flags appear on the following clock edge, with `out_valid` high for one cycle. A small state machine tracks the stage and has two states. ST_EMPTY means the stage holds nothing. ST_FULL means the stage holds a result. The transition "accept" (in_valid high) leads from either state to ST_FULL. The transition "drain" (in_valid low) leads from either state to ST_EMPTY. A synchronous reset forces ST_EMPTY.

Top module: `bfx_unit`

## Requirements
- R1: The start position is read from `ctrl_word[7:0]` and the length from `ctrl_word[15:8]`, both as unsigned values. Bits 63:16 of `ctrl_word` have no effect on any output.
- R2: Result bit i equals source bit (start + i) for i below the length, and every result bit at position length or above is zero.
- R3: If the start is equal to or greater than the operand size (32 or 64), the result is all zeros.
- R4: Source positions at or above the operand size read as zero. A field that runs past the top of the operand therefore returns only the bits that exist, zero-filled above them.
- R5: `wide_mode` = 1 selects a 64-bit operand and `wide_mode` = 0 selects a 32-bit operand. In 32-bit mode, `src_data[63:32]` has no effect and `result[63:32]` is zero.
- R6: `flags` is ordered {OF, SF, ZF, AF, PF, CF}, from bit 5 down to bit 0. Bit 3 (ZF) is 1 exactly when the result is zero.
- R7: Flag bits 5, 4, 2, 1 and 0 are always zero.
- R8: A length of zero gives a zero result with ZF set, for any start value.
- R9: An operand presented with `in_valid` high at a rising edge produces its result on the next rising edge, with `out_valid` high for exactly that cycle. Whenever `out_valid` is low, `result` and `flags` are zero.
- R10: A synchronous active-high `rst` clears `out_valid`, `result` and `flags`. Operands presented while `rst` is high produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| wide_mode | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| src_data | input | 64 | Word the field is taken from |
| ctrl_word | input | 64 | Start in bits 7:0, length in bits 15:8 |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 64 | Right-justified extracted field |
| flags | output | 6 | {OF, SF, ZF, AF, PF, CF} |

## Verification
The bench builds the unit with its default parameters: a 64-bit data path, a 32-bit narrow size and 8-bit start and length fields. Because the fields are 8 bits wide, starts and lengths up to 255 can be driven. This covers starts at and far beyond both operand sizes, lengths that exceed the operand, and fields that straddle the top bit in both modes. Directed cases for these edges, back-to-back and gapped operands, and a reset in the middle of traffic are followed by a long run of random operands. In that run the start and length are drawn so that about half of them land out of range.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    // Flag vector layout {OF, SF, ZF, AF, PF, CF}
    localparam int FLAG_W = 6;
    localparam int FLG_CF = 0;
    localparam int FLG_PF = 1;
    localparam int FLG_AF = 2;
    localparam int FLG_ZF = 3;
    localparam int FLG_SF = 4;
    localparam int FLG_OF = 5;

    // Occupancy of the single register stage
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } bfx_state_e;

endpackage

// File: rtl/bfx_ctrl_decode.sv
module bfx_ctrl_decode #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int POS_W    = 8,
    localparam int IDX_W   = $clog2(DATA_W),
    localparam int CNT_W   = IDX_W + 1
) (
    input  logic               wide_i,
    input  logic [2*POS_W-1:0] ctrl_i,
    output logic [IDX_W-1:0]   start_idx_o,
    output logic               start_oob_o,
    output logic [CNT_W-1:0]   len_eff_o
);
    localparam int CMP_W = ((POS_W > CNT_W) ? POS_W : CNT_W) + 1;

    logic [CMP_W-1:0] size_c;
    logic [CMP_W-1:0] start_c;
    logic [CMP_W-1:0] len_c;

    always_comb begin
        size_c  = wide_i ? CMP_W'(DATA_W) : CMP_W'(NARROW_W);
        start_c = CMP_W'(ctrl_i[POS_W-1:0]);
        len_c   = CMP_W'(ctrl_i[2*POS_W-1:POS_W]);
    end

    // Start past the operand: nothing is extracted
    assign start_oob_o = (start_c >= size_c);
    assign start_idx_o = start_c[IDX_W-1:0];

    // Length clamps to the operand size instead of wrapping
    always_comb begin
        if (len_c >= size_c) begin
            len_eff_o = size_c[CNT_W-1:0];
        end else begin
            len_eff_o = len_c[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen #(
    parameter int DATA_W = 64,
    localparam int CNT_W = $clog2(DATA_W) + 1
) (
    input  logic [CNT_W-1:0]  len_i,
    output logic [DATA_W-1:0] mask_o
);
    // Thermometer mask: ones below the effective length
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign mask_o[i] = (CNT_W'(i) < len_i);
    end

endmodule

// File: rtl/bfx_shifter.sv
module bfx_shifter #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    localparam int IDX_W   = $clog2(DATA_W)
) (
    input  logic              wide_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  start_idx_i,
    input  logic              start_oob_i,
    output logic [DATA_W-1:0] field_o
);
    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [DATA_W-1:0] src_c;
    logic [DATA_W-1:0] shifted_c;

    // Narrow mode: the upper source half reads as zero
    assign src_c     = wide_i ? data_i : (data_i & NARROW_MASK);
    assign shifted_c = src_c >> start_idx_i;
    assign field_o   = start_oob_i ? '0 : shifted_c;

endmodule

// File: rtl/bfx_flag_gen.sv
module bfx_flag_gen
    import bfx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] result_i,
    output logic [FLAG_W-1:0] flags_o
);
    always_comb begin
        flags_o         = '0;
        flags_o[FLG_ZF] = ~|result_i;
        flags_o[FLG_CF] = 1'b0;
        flags_o[FLG_OF] = 1'b0;
        flags_o[FLG_SF] = 1'b0;
        flags_o[FLG_AF] = 1'b0;
        flags_o[FLG_PF] = 1'b0;
    end

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int POS_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              wide_mode,
    input  logic [DATA_W-1:0] src_data,
    input  logic [DATA_W-1:0] ctrl_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int CNT_W = IDX_W + 1;

    bfx_state_e        state_q;
    bfx_state_e        state_d;
    logic [IDX_W-1:0]  start_idx;
    logic              start_oob;
    logic [CNT_W-1:0]  len_eff;
    logic [DATA_W-1:0] len_mask;
    logic [DATA_W-1:0] field;
    logic [DATA_W-1:0] res_c;
    logic [FLAG_W-1:0] flag_c;
    logic [DATA_W-1:0] result_q;
    logic [FLAG_W-1:0] flags_q;
    logic              ctrl_unused;

    // Control bits above the two fields take no part
    assign ctrl_unused = ^ctrl_word[DATA_W-1:2*POS_W];

    bfx_ctrl_decode #(
        .DATA_W  (DATA_W),
        .NARROW_W(NARROW_W),
        .POS_W   (POS_W)
    ) u_decode (
        .wide_i     (wide_mode),
        .ctrl_i     (ctrl_word[2*POS_W-1:0]),
        .start_idx_o(start_idx),
        .start_oob_o(start_oob),
        .len_eff_o  (len_eff)
    );

    bfx_mask_gen #(
        .DATA_W(DATA_W)
    ) u_mask (
        .len_i (len_eff),
        .mask_o(len_mask)
    );

    bfx_shifter #(
        .DATA_W  (DATA_W),
        .NARROW_W(NARROW_W)
    ) u_shift (
        .wide_i     (wide_mode),
        .data_i     (src_data),
        .start_idx_i(start_idx),
        .start_oob_i(start_oob),
        .field_o    (field)
    );

    assign res_c = field & len_mask;

    bfx_flag_gen #(
        .DATA_W(DATA_W)
    ) u_flags (
        .result_i(res_c),
        .flags_o (flag_c)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: zero unless an operand was accepted
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
        end else if (in_valid) begin
            result_q <= res_c;
            flags_q  <= flag_c;
        end else begin
            result_q <= '0;
            flags_q  <= '0;
        end
    end

    assign out_valid = (state_q == ST_FULL);
    assign result    = result_q;
    assign flags     = flags_q;

endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int POS_W    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              wide_mode,
    input logic [DATA_W-1:0] src_data,
    input logic [DATA_W-1:0] ctrl_word,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [5:0]        flags
);
    logic [POS_W:0] chk_start;
    logic [POS_W:0] chk_size;
    logic           chk_oob;
    logic           chk_len_zero;

    assign chk_start    = {1'b0, ctrl_word[POS_W-1:0]};
    assign chk_size     = wide_mode ? (POS_W+1)'(DATA_W) : (POS_W+1)'(NARROW_W);
    assign chk_oob      = (chk_start >= chk_size);
    assign chk_len_zero = (ctrl_word[2*POS_W-1:POS_W] == '0);

    p_accept_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_drain_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (result == '0 && flags == '0));

    p_zf_match_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags[3] == (result == '0)));

    p_flags_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (flags[5] == 1'b0 && flags[4] == 1'b0 && flags[2:0] == 3'b000));

    p_start_oob_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(chk_oob)) |-> (result == '0));

    p_narrow_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(wide_mode)) |-> (result[DATA_W-1:NARROW_W] == '0));

    p_len_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(chk_len_zero)) |-> (result == '0 && flags[3]));

    p_reset_r10: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && result == '0 && flags == '0));

endmodule

bind bfx_unit bfx_unit_chk #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W),
    .POS_W   (POS_W)
) u_bfx_unit_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .wide_mode(wide_mode),
    .src_data (src_data),
    .ctrl_word(ctrl_word),
    .out_valid(out_valid),
    .result   (result),
    .flags    (flags)
);

// File: tb/test_bfx_unit.sv
`timescale 1ns/1ps
module test_bfx_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        wide_mode = 1'b0;
    logic [63:0] src_data = '0;
    logic [63:0] ctrl_word = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [5:0]  flags;

    int checks = 0;
    int errors = 0;

    logic        exp_v;
    logic [63:0] exp_r;
    logic [5:0]  exp_f;

    always #10 clk = ~clk;

    bfx_unit i_bfx_unit (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .wide_mode(wide_mode),
        .src_data (src_data),
        .ctrl_word(ctrl_word),
        .out_valid(out_valid),
        .result   (result),
        .flags    (flags)
    );

    // Behavioural reference: walk the field bit by bit
    function automatic logic [63:0] ref_extract(input logic w, input logic [63:0] d,
                                                input logic [63:0] c);
        int size  = w ? 64 : 32;
        int start = int'(c[7:0]);
        int len   = int'(c[15:8]);
        logic [63:0] r = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < len && (start + i) < size) r[i] = d[start + i];
        end
        return r;
    endfunction

    function automatic logic [63:0] mk_ctrl(input int start, input int len,
                                            input logic [47:0] junk);
        return {junk, 8'(len), 8'(start)};
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (out_valid !== exp_v || result !== exp_r || flags !== exp_f) begin
            errors++;
            $display("FAIL %s: got v=%0b r=%h f=%b, expected v=%0b r=%h f=%b",
                     tag, out_valid, result, flags, exp_v, exp_r, exp_f);
        end
    endtask

    // Drive one cycle at the falling edge, model the rising edge, check at the next fall
    task automatic cycle(input logic r, input logic v, input logic w,
                         input logic [63:0] d, input logic [63:0] c, input string tag);
        rst = r; in_valid = v; wide_mode = w; src_data = d; ctrl_word = c;
        @(posedge clk);
        if (r || !v) begin
            exp_v = 1'b0; exp_r = '0; exp_f = '0;
        end else begin
            exp_v = 1'b1;
            exp_r = ref_extract(w, d, c);
            exp_f = {2'b00, (exp_r == '0), 3'b000};
        end
        @(negedge clk);
        compare(tag);
    endtask

    localparam logic [63:0] PAT = 64'hFEDC_BA98_7654_3210;

    initial begin
        @(negedge clk);
        cycle(1, 1, 1, PAT, mk_ctrl(0, 8, '0), "R10 reset");
        cycle(1, 0, 0, '0, '0, "R10 reset");
        // Main function
        cycle(0, 1, 1, PAT, mk_ctrl(4, 8, '0), "R2 mid field");
        cycle(0, 1, 1, PAT, mk_ctrl(0, 64, '0), "R2 full word");
        cycle(0, 1, 1, PAT, mk_ctrl(60, 8, '0), "R4 overrun wide");
        cycle(0, 1, 1, PAT, mk_ctrl(0, 255, '0), "R4 length clamp");
        cycle(0, 1, 1, PAT, mk_ctrl(64, 8, '0), "R3 start at size wide");
        cycle(0, 1, 1, PAT, mk_ctrl(255, 255, '0), "R3 start max");
        cycle(0, 1, 0, PAT, mk_ctrl(32, 4, '0), "R3 start at size narrow");
        cycle(0, 1, 0, PAT, mk_ctrl(0, 64, '0), "R5 narrow upper ignored");
        cycle(0, 1, 0, PAT, mk_ctrl(28, 16, '0), "R5 narrow overrun");
        cycle(0, 1, 1, PAT, mk_ctrl(9, 0, '0), "R8 zero length");
        cycle(0, 1, 0, PAT, mk_ctrl(200, 0, '0), "R8 zero length oob");
        cycle(0, 1, 1, PAT, mk_ctrl(8, 12, 48'hFFFF_FFFF_FFFF), "R1 upper control ignored");
        cycle(0, 1, 1, 64'h0, mk_ctrl(3, 20, '0), "R6 zero result sets ZF");
        cycle(0, 0, 1, PAT, mk_ctrl(4, 8, '0), "R9 drain");
        cycle(0, 0, 0, '0, '0, "R9 idle");
        cycle(0, 1, 1, PAT, mk_ctrl(1, 1, '0), "R9 accept after gap");
        cycle(0, 1, 1, ~PAT, mk_ctrl(63, 1, '0), "R2 top bit");
        cycle(1, 1, 1, PAT, mk_ctrl(0, 8, '0), "R10 mid-stream reset");
        cycle(0, 0, 1, PAT, mk_ctrl(0, 8, '0), "R10 after reset");
        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] d = {$urandom, $urandom};
            logic [47:0] j = {16'($urandom), $urandom};
            int st = ($urandom % 2) ? int'($urandom % 72) : int'($urandom % 256);
            int ln = ($urandom % 2) ? int'($urandom % 72) : int'($urandom % 256);
            cycle(0, 1'($urandom % 4 != 0), 1'($urandom), d, mk_ctrl(st, ln, j),
                  "R7 random");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule